// File: doc/BRIEF.md
# Package-Aware Pin Function Multiplexer

This combinational block sits between three pads of one port and the peripherals that can claim them. For each pad it selects a single owner from a fixed priority chain, drives the pad output value and output enable from that owner, and routes the pad input back to the peripherals that sample it. The general-purpose data and direction bits own a pad only when no bonded peripheral on it is enabled.

The priority chains, and the set of functions that are present, depend on a 2-bit package-variant select. Each function also has its own rule for the pad direction. For SPI and UART transmit, the peripheral sets the direction. PWM, the bus clock output, the periodic-interrupt clock output and timer output-compare each force the pad to output. The ADC trigger tap does not affect the direction. On the 32-pin variant, a comparator-to-timer link can take the timer channel 5 capture input away from the pad.

Top module: `pin_mux`

## Requirements
- R1: Package select encoding is 0 = 20-pin, 1 = 32-pin, 2 = 48/64-pin, 3 = 100-pin. On pad 2 with select 0 the owner is the first enabled of: SPI select, UART transmit, PWM3, bus clock, periodic clock, general-purpose.
- R2: On pad 2 with select 1 the owner is the first enabled of: SPI select, PWM5, bus clock, periodic clock, general-purpose.
- R3: On pad 2, select 2 uses SPI select, bus clock, periodic clock, general-purpose, and select 3 uses SPI select, periodic clock, general-purpose.
- R4: When an SPI function owns a pad, the pad output equals that SPI output and the pad enable equals that SPI direction request.
- R5: When UART transmit owns pad 2, the pad output equals the transmit value and the pad enable equals the UART direction request.
- R6: When PWM, bus clock, periodic clock or timer output-compare owns a pad, the pad enable is 1 and the pad output equals that function's value.
- R7: Pad 1 uses the chain SPI clock, then timer channel 3 (select 0) or timer channel 5 (select 1), then general-purpose. Selects 2 and 3 have no timer step.
- R8: Pad 0 uses the chain SPI MOSI, then timer channel 2 (select 0) or timer channel 4 (select 1), then general-purpose. Selects 2 and 3 have no timer step.
- R9: A pad with no owning peripheral drives its output from the general-purpose data bit and its enable from the general-purpose direction bit.
- R10: An enable of a function that is not bonded in the selected variant has no effect on any pad.
- R11: The ADC trigger output equals pad 2 input when select is 0 and PWM3 is enabled, and is 0 otherwise. The tap never changes a pad enable.
- R12: The timer capture inputs follow the pad only in their own variant and are 0 otherwise. With select 1 and the comparator link set, the channel 5 capture follows the comparator output instead of pad 1.
- R13: The SPI select, clock and MOSI inputs always follow pads 2, 1 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pkg_sel | input | 2 | Package variant select |
| gp_data | input | 3 | General-purpose output data, one bit per pad |
| gp_dir | input | 3 | General-purpose direction, 1 = output |
| spi_ss_en | input | 1 | SPI select function enabled |
| spi_ss_out | input | 1 | SPI select output value |
| spi_ss_oe | input | 1 | SPI select direction request |
| spi_sck_en | input | 1 | SPI clock function enabled |
| spi_sck_out | input | 1 | SPI clock output value |
| spi_sck_oe | input | 1 | SPI clock direction request |
| spi_mosi_en | input | 1 | SPI MOSI function enabled |
| spi_mosi_out | input | 1 | SPI MOSI output value |
| spi_mosi_oe | input | 1 | SPI MOSI direction request |
| uart_tx_en | input | 1 | UART transmit enabled |
| uart_tx_out | input | 1 | UART transmit value |
| uart_tx_oe | input | 1 | UART direction request |
| pwm3_en | input | 1 | PWM channel 3 enabled |
| pwm3_out | input | 1 | PWM channel 3 value |
| pwm5_en | input | 1 | PWM channel 5 enabled |
| pwm5_out | input | 1 | PWM channel 5 value |
| bclk_en | input | 1 | Bus clock output enabled |
| bclk_out | input | 1 | Bus clock value |
| pclk_en | input | 1 | Periodic-interrupt clock output enabled |
| pclk_out | input | 1 | Periodic-interrupt clock value |
| tim2_oc_en | input | 1 | Timer channel 2 output-compare enabled |
| tim2_out | input | 1 | Timer channel 2 value |
| tim3_oc_en | input | 1 | Timer channel 3 output-compare enabled |
| tim3_out | input | 1 | Timer channel 3 value |
| tim4_oc_en | input | 1 | Timer channel 4 output-compare enabled |
| tim4_out | input | 1 | Timer channel 4 value |
| tim5_oc_en | input | 1 | Timer channel 5 output-compare enabled |
| tim5_out | input | 1 | Timer channel 5 value |
| cmp_link_en | input | 1 | Comparator-to-timer link enabled |
| cmp_out | input | 1 | Comparator output |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output values |
| pad_oe | output | 3 | Pad output enables |
| spi_ss_in | output | 1 | Pad 2 level to SPI |
| spi_sck_in | output | 1 | Pad 1 level to SPI |
| spi_mosi_in | output | 1 | Pad 0 level to SPI |
| adc_trig | output | 1 | ADC external trigger tap |
| tim2_in | output | 1 | Timer channel 2 capture input |
| tim3_in | output | 1 | Timer channel 3 capture input |
| tim4_in | output | 1 | Timer channel 4 capture input |
| tim5_in | output | 1 | Timer channel 5 capture input |

## Verification
The block holds no state. A wrong priority decision or a wrong variant decode therefore shows at the pad output and enable in the same cycle the inputs change. No delay or masking can hide it. The faults most likely to go unseen are a mis-ordered chain step or an unbonded function that still leaks through. Both appear only when two owners compete on one pad under one variant. For this reason the stimulus sweeps many random enable combinations across all four package selects and compares every output against the model on every clock.

// File: rtl/pin_mux.sv
module pin_mux (
  input  logic [1:0] pkg_sel,
  input  logic [2:0] gp_data,
  input  logic [2:0] gp_dir,
  input  logic       spi_ss_en,
  input  logic       spi_ss_out,
  input  logic       spi_ss_oe,
  input  logic       spi_sck_en,
  input  logic       spi_sck_out,
  input  logic       spi_sck_oe,
  input  logic       spi_mosi_en,
  input  logic       spi_mosi_out,
  input  logic       spi_mosi_oe,
  input  logic       uart_tx_en,
  input  logic       uart_tx_out,
  input  logic       uart_tx_oe,
  input  logic       pwm3_en,
  input  logic       pwm3_out,
  input  logic       pwm5_en,
  input  logic       pwm5_out,
  input  logic       bclk_en,
  input  logic       bclk_out,
  input  logic       pclk_en,
  input  logic       pclk_out,
  input  logic       tim2_oc_en,
  input  logic       tim2_out,
  input  logic       tim3_oc_en,
  input  logic       tim3_out,
  input  logic       tim4_oc_en,
  input  logic       tim4_out,
  input  logic       tim5_oc_en,
  input  logic       tim5_out,
  input  logic       cmp_link_en,
  input  logic       cmp_out,
  input  logic [2:0] pad_in,
  output logic [2:0] pad_out,
  output logic [2:0] pad_oe,
  output logic       spi_ss_in,
  output logic       spi_sck_in,
  output logic       spi_mosi_in,
  output logic       adc_trig,
  output logic       tim2_in,
  output logic       tim3_in,
  output logic       tim4_in,
  output logic       tim5_in
);
  localparam logic [1:0] PKG20 = 2'd0;
  localparam logic [1:0] PKG32 = 2'd1;
  localparam logic [1:0] PKG100 = 2'd3;

  logic is20, is32, has_bclk;
  assign is20     = (pkg_sel == PKG20);
  assign is32     = (pkg_sel == PKG32);
  assign has_bclk = (pkg_sel != PKG100);

  // pad 2
  always_comb begin
    if (spi_ss_en) begin
      pad_out[2] = spi_ss_out;  pad_oe[2] = spi_ss_oe;
    end else if (is20 && uart_tx_en) begin
      pad_out[2] = uart_tx_out; pad_oe[2] = uart_tx_oe;
    end else if (is20 && pwm3_en) begin
      pad_out[2] = pwm3_out;    pad_oe[2] = 1'b1;
    end else if (is32 && pwm5_en) begin
      pad_out[2] = pwm5_out;    pad_oe[2] = 1'b1;
    end else if (has_bclk && bclk_en) begin
      pad_out[2] = bclk_out;    pad_oe[2] = 1'b1;
    end else if (pclk_en) begin
      pad_out[2] = pclk_out;    pad_oe[2] = 1'b1;
    end else begin
      pad_out[2] = gp_data[2];  pad_oe[2] = gp_dir[2];
    end
  end

  // pad 1
  always_comb begin
    if (spi_sck_en) begin
      pad_out[1] = spi_sck_out; pad_oe[1] = spi_sck_oe;
    end else if (is20 && tim3_oc_en) begin
      pad_out[1] = tim3_out;    pad_oe[1] = 1'b1;
    end else if (is32 && tim5_oc_en) begin
      pad_out[1] = tim5_out;    pad_oe[1] = 1'b1;
    end else begin
      pad_out[1] = gp_data[1];  pad_oe[1] = gp_dir[1];
    end
  end

  // pad 0
  always_comb begin
    if (spi_mosi_en) begin
      pad_out[0] = spi_mosi_out; pad_oe[0] = spi_mosi_oe;
    end else if (is20 && tim2_oc_en) begin
      pad_out[0] = tim2_out;     pad_oe[0] = 1'b1;
    end else if (is32 && tim4_oc_en) begin
      pad_out[0] = tim4_out;     pad_oe[0] = 1'b1;
    end else begin
      pad_out[0] = gp_data[0];   pad_oe[0] = gp_dir[0];
    end
  end

  assign spi_ss_in   = pad_in[2];
  assign spi_sck_in  = pad_in[1];
  assign spi_mosi_in = pad_in[0];
  assign adc_trig    = is20 & pwm3_en & pad_in[2];
  assign tim3_in     = is20 & pad_in[1];
  assign tim2_in     = is20 & pad_in[0];
  assign tim4_in     = is32 & pad_in[0];
  assign tim5_in     = is32 & (cmp_link_en ? cmp_out : pad_in[1]);
endmodule

// File: rtl/pin_mux_chk.sv
module pin_mux_chk (
  input logic [1:0] pkg_sel,
  input logic [2:0] gp_data,
  input logic [2:0] gp_dir,
  input logic       spi_ss_en,
  input logic       spi_ss_oe,
  input logic       spi_sck_en,
  input logic       spi_sck_oe,
  input logic       spi_mosi_en,
  input logic       spi_mosi_oe,
  input logic       uart_tx_en,
  input logic       uart_tx_oe,
  input logic       pwm3_en,
  input logic       bclk_en,
  input logic       pclk_en,
  input logic       tim2_oc_en,
  input logic       tim4_oc_en,
  input logic       cmp_link_en,
  input logic       cmp_out,
  input logic [2:0] pad_in,
  input logic [2:0] pad_oe,
  input logic [2:0] pad_out,
  input logic       spi_ss_in,
  input logic       adc_trig,
  input logic       tim5_in
);
  always_comb begin
    AST_SS_DIR: assert (!spi_ss_en || pad_oe[2] == spi_ss_oe); // R4
    AST_SCK_DIR: assert (!spi_sck_en || pad_oe[1] == spi_sck_oe); // R4
    AST_MOSI_DIR: assert (!spi_mosi_en || pad_oe[0] == spi_mosi_oe); // R4
    AST_UART_DIR: assert (!(pkg_sel == 2'd0 && !spi_ss_en && uart_tx_en) || pad_oe[2] == uart_tx_oe); // R5
    AST_BCLK_FORCE: assert (!(pkg_sel == 2'd2 && !spi_ss_en && bclk_en) || pad_oe[2]); // R6
    AST_GP_FALLBACK: assert (!(!spi_mosi_en && !tim2_oc_en && !tim4_oc_en) ||
                             (pad_oe[0] == gp_dir[0] && pad_out[0] == gp_data[0])); // R9
    AST_UNBONDED: assert (!(pkg_sel == 2'd3 && !spi_ss_en && !pclk_en) ||
                          (pad_oe[2] == gp_dir[2] && pad_out[2] == gp_data[2])); // R10
    AST_TRIG_TAP: assert (adc_trig == (pkg_sel == 2'd0 && pwm3_en && pad_in[2])); // R11
    AST_CMP_LINK: assert (!(pkg_sel == 2'd1 && cmp_link_en) || tim5_in == cmp_out); // R12
    AST_SS_IN: assert (spi_ss_in == pad_in[2]); // R13
  end
endmodule

bind pin_mux pin_mux_chk u_chk (
  .pkg_sel(pkg_sel), .gp_data(gp_data), .gp_dir(gp_dir),
  .spi_ss_en(spi_ss_en), .spi_ss_oe(spi_ss_oe),
  .spi_sck_en(spi_sck_en), .spi_sck_oe(spi_sck_oe),
  .spi_mosi_en(spi_mosi_en), .spi_mosi_oe(spi_mosi_oe),
  .uart_tx_en(uart_tx_en), .uart_tx_oe(uart_tx_oe),
  .pwm3_en(pwm3_en), .bclk_en(bclk_en), .pclk_en(pclk_en),
  .tim2_oc_en(tim2_oc_en), .tim4_oc_en(tim4_oc_en),
  .cmp_link_en(cmp_link_en), .cmp_out(cmp_out), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .spi_ss_in(spi_ss_in),
  .adc_trig(adc_trig), .tim5_in(tim5_in)
);

// File: tb/pin_mux_tb.sv
module pin_mux_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] pkg_sel;
  logic [2:0] gp_data, gp_dir, pad_in;
  logic spi_ss_en, spi_ss_out, spi_ss_oe, spi_sck_en, spi_sck_out, spi_sck_oe;
  logic spi_mosi_en, spi_mosi_out, spi_mosi_oe, uart_tx_en, uart_tx_out, uart_tx_oe;
  logic pwm3_en, pwm3_out, pwm5_en, pwm5_out, bclk_en, bclk_out, pclk_en, pclk_out;
  logic tim2_oc_en, tim2_out, tim3_oc_en, tim3_out, tim4_oc_en, tim4_out, tim5_oc_en, tim5_out;
  logic cmp_link_en, cmp_out;
  logic [2:0] pad_out, pad_oe;
  logic spi_ss_in, spi_sck_in, spi_mosi_in, adc_trig, tim2_in, tim3_in, tim4_in, tim5_in;

  pin_mux u_dut (.*);

  int vectors = 0;
  int fails = 0;
  bit running = 1'b1;

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b pkg=%0d t=%0t", tag, act, exp, pkg_sel, $time);
    end
  endtask

  // function ids: 0 spi,1 uart,2 pwm3,3 pwm5,4 bclk,5 pclk,6 tim-a,7 tim-b,8 gp
  function automatic bit fen(int id, int pin);
    case (id)
      0: return pin == 2 ? spi_ss_en : pin == 1 ? spi_sck_en : spi_mosi_en;
      1: return uart_tx_en;
      2: return pwm3_en;
      3: return pwm5_en;
      4: return bclk_en;
      5: return pclk_en;
      6: return pin == 1 ? tim3_oc_en : tim2_oc_en;
      7: return pin == 1 ? tim5_oc_en : tim4_oc_en;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_pin(int pin);
    int chain[$];
    int win;
    logic eo, ee;
    string tag;
    if (pin == 2) begin
      case (pkg_sel)
        2'd0: chain = '{0, 1, 2, 4, 5, 8};
        2'd1: chain = '{0, 3, 4, 5, 8};
        2'd2: chain = '{0, 4, 5, 8};
        default: chain = '{0, 5, 8};
      endcase
      tag = pkg_sel == 0 ? "R1" : pkg_sel == 1 ? "R2" : "R3";
    end else begin
      case (pkg_sel)
        2'd0: chain = '{0, 6, 8};
        2'd1: chain = '{0, 7, 8};
        default: chain = '{0, 8};
      endcase
      tag = pin == 1 ? "R7" : "R8";
    end
    win = 8;
    foreach (chain[i]) if (fen(chain[i], pin)) begin win = chain[i]; break; end
    case (win)
      0: begin
        eo = pin == 2 ? spi_ss_out : pin == 1 ? spi_sck_out : spi_mosi_out;
        ee = pin == 2 ? spi_ss_oe : pin == 1 ? spi_sck_oe : spi_mosi_oe;
        tag = {tag, ",R4"};
      end
      1: begin eo = uart_tx_out; ee = uart_tx_oe; tag = {tag, ",R5"}; end
      2: begin eo = pwm3_out; ee = 1; tag = {tag, ",R6,R11"}; end
      3: begin eo = pwm5_out; ee = 1; tag = {tag, ",R6"}; end
      4: begin eo = bclk_out; ee = 1; tag = {tag, ",R6"}; end
      5: begin eo = pclk_out; ee = 1; tag = {tag, ",R6"}; end
      6: begin eo = pin == 1 ? tim3_out : tim2_out; ee = 1; tag = {tag, ",R6"}; end
      7: begin eo = pin == 1 ? tim5_out : tim4_out; ee = 1; tag = {tag, ",R6"}; end
      default: begin eo = gp_data[pin]; ee = gp_dir[pin]; tag = {tag, ",R9"}; end
    endcase
    if (pkg_sel >= 2 || (pin == 2 && pkg_sel == 1 && (uart_tx_en || pwm3_en)))
      tag = {tag, ",R10"};
    chk({tag, " out"}, pad_out[pin], eo);
    chk({tag, " oe"}, pad_oe[pin], ee);
  endtask

  always @(negedge clk) if (running) begin
    for (int p = 0; p < 3; p++) model_pin(p);
    chk("R11 trig", adc_trig, (pkg_sel == 0 && pwm3_en) ? pad_in[2] : 1'b0);
    chk("R12 tim2", tim2_in, pkg_sel == 0 ? pad_in[0] : 1'b0);
    chk("R12 tim3", tim3_in, pkg_sel == 0 ? pad_in[1] : 1'b0);
    chk("R12 tim4", tim4_in, pkg_sel == 1 ? pad_in[0] : 1'b0);
    chk("R12 tim5", tim5_in, pkg_sel != 1 ? 1'b0 : cmp_link_en ? cmp_out : pad_in[1]);
    chk("R13 ss", spi_ss_in, pad_in[2]);
    chk("R13 sck", spi_sck_in, pad_in[1]);
    chk("R13 mosi", spi_mosi_in, pad_in[0]);
  end

  task automatic clear();
    {pkg_sel, gp_data, gp_dir, pad_in} = '0;
    {spi_ss_en, spi_ss_out, spi_ss_oe, spi_sck_en, spi_sck_out, spi_sck_oe} = '0;
    {spi_mosi_en, spi_mosi_out, spi_mosi_oe, uart_tx_en, uart_tx_out, uart_tx_oe} = '0;
    {pwm3_en, pwm3_out, pwm5_en, pwm5_out, bclk_en, bclk_out, pclk_en, pclk_out} = '0;
    {tim2_oc_en, tim2_out, tim3_oc_en, tim3_out, tim4_oc_en, tim4_out, tim5_oc_en, tim5_out} = '0;
    {cmp_link_en, cmp_out} = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    clear();
    step();
    // reset-like idle state: all outputs low (R9)
    @(negedge clk); #1;
    chk("R9 idle out", |pad_out, 1'b0);
    chk("R9 idle oe", |pad_oe, 1'b0);
    // R10: unbonded enables in 100-pin variant, pad stays general-purpose
    pkg_sel = 2'd3; uart_tx_en = 1; pwm3_en = 1; pwm5_en = 1; bclk_en = 1;
    tim2_oc_en = 1; tim3_oc_en = 1; gp_dir = 3'b000; gp_data = 3'b000;
    bclk_out = 1; pwm3_out = 1; tim2_out = 1; tim3_out = 1;
    step();
    // R6: pclk forces output in 100-pin
    pclk_en = 1; pclk_out = 1; step();
    // R12: comparator link in 32-pin
    clear(); pkg_sel = 2'd1; cmp_link_en = 1; cmp_out = 1; pad_in = 3'b000; step();
    cmp_out = 0; pad_in = 3'b111; step();
    // R11: trigger tap in 20-pin with SPI owning pad as input
    clear(); pwm3_en = 1; spi_ss_en = 1; spi_ss_oe = 0; pad_in = 3'b100; step();
    // R5: UART owns pad 2 as input
    spi_ss_en = 0; uart_tx_en = 1; uart_tx_oe = 0; uart_tx_out = 1; step();
    for (int n = 0; n < 3000; n++) begin
      {pkg_sel, gp_data, gp_dir, pad_in} = 11'($urandom);
      {spi_ss_en, spi_ss_out, spi_ss_oe, spi_sck_en, spi_sck_out, spi_sck_oe} = 6'($urandom);
      {spi_mosi_en, spi_mosi_out, spi_mosi_oe, uart_tx_en, uart_tx_out, uart_tx_oe} = 6'($urandom);
      {pwm3_en, pwm3_out, pwm5_en, pwm5_out, bclk_en, bclk_out, pclk_en, pclk_out} = 8'($urandom);
      {tim2_oc_en, tim2_out, tim3_oc_en, tim3_out, tim4_oc_en, tim4_out, tim5_oc_en, tim5_out} = 8'($urandom);
      {cmp_link_en, cmp_out} = 2'($urandom);
      if (n % 3 != 0) begin
        spi_ss_en = 0; spi_sck_en = 0; spi_mosi_en = 0;
      end
      step();
    end
    step();
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    running = 0;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule